// File: doc/BRIEF.md
# Multi-Sector Erase Scheduler

This block collects requests to erase 64 KB sectors of an eight-sector array. The first sector request opens an acceptance window. Each further request made while the window is open adds one more sector and starts the window again. When the window runs out, the block erases the collected sectors one at a time on a modelled erase engine. The engine is a per-sector cycle counter. Sectors that are marked protected are never collected. A whole-array erase loads every unprotected sector at once and starts straight away, with no window.

The block accepts a suspend command during the window or during a sector-by-sector erase, and a resume command afterwards. A command that does not belong in the window cancels the whole request. While the erase runs, or while it is suspended, the block ignores stray commands. A per-sector cycle limit detects an engine that makes no progress: when the limit runs out, the erase is abandoned and a failure flag is raised. Commands arrive as single-cycle pulses that a bus decoder upstream has already decoded. The array contents are not handled here.

Top module: `erase_sched`

## Requirements
- R1: After reset, busy, window-open, suspended, done and the failure flag are all 0, and the sector mask is 0.
- R2: In the idle state, a sector-add pulse sets bit n of the mask, where n is the 3-bit sector number, and holds window-open high for WIN_CYC cycles. A further sector-add during the window ORs its bit into the mask, and window-open then stays high for WIN_CYC cycles from that pulse.
- R3: When the window expires, the erase starts. The set bits are erased in ascending index order. Each bit clears ERASE_CYC cycles after its sector starts, so the last bit clears WIN_CYC + k*ERASE_CYC cycles after the last sector-add, where k is the number of sectors. When the mask empties, busy falls and done is high for exactly one cycle.
- R4: During the window, a chip-erase, reset, resume or other-command pulse cancels the request. In the next cycle busy is 0 and the mask is 0.
- R5: A suspend pulse during the window closes the window and raises suspended in the next cycle. A later resume starts the erase, and the first sector finishes ERASE_CYC cycles after the resume.
- R6: A suspend pulse during a sector-by-sector erase raises suspended exactly SUSP_LAT cycles after the pulse. The engine keeps working during those cycles. The mask stays frozen while suspended.
- R7: While suspended, only resume has an effect. After a suspend, reset, other-command, chip-erase or sector-add pulse, the block is still suspended and the mask is unchanged. A resume pulse clears suspended in the next cycle, and busy stays high.
- R8: A resume pulse while the block is not suspended is ignored. After a resume, a new suspend is accepted with the same SUSP_LAT latency.
- R9: In the idle state, a chip-erase pulse loads the mask with every unprotected sector and starts erasing at once, with no window. Suspend is ignored for the whole of a chip erase.
- R10: Once the erase is running, every pulse except suspend is ignored. No bit is ever added to the mask, and the total erase time is unchanged.
- R11: A sector whose protect bit is 1 never enters the mask. If the window closes with an empty mask, done pulses one cycle later.
- R12: If the current sector has not finished after LIMIT_CYC running cycles, the failure flag is set and the erase is abandoned: busy and the mask drop to 0. The next accepted sector-add or chip-erase clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_sect_add | input | 1 | Sector erase request pulse |
| cmd_sect_num | input | 3 | Sector number for cmd_sect_add |
| cmd_chip | input | 1 | Whole-array erase pulse |
| cmd_suspend | input | 1 | Suspend pulse |
| cmd_resume | input | 1 | Resume pulse |
| cmd_reset | input | 1 | Return-to-read pulse |
| cmd_other | input | 1 | Any other decoded command |
| protect_mask | input | 8 | Per-sector protection, 1 = protected |
| eng_stall | input | 1 | Model input: engine makes no progress while high |
| busy | output | 1 | Request held, window, erase or suspend in progress |
| win_open | output | 1 | Acceptance window open |
| suspended | output | 1 | Erase suspended |
| done | output | 1 | One-cycle pulse when the mask empties |
| sector_mask | output | 8 | Sectors still to erase |
| timeout_fail | output | 1 | Sticky per-sector limit failure |

## Verification
The bench targets window restart. A design that counted from the first request instead of the last would close the window early, and the measured time to done would come out shorter. It checks that erasing runs in ascending order: a design with a wrong priority encoder would clear a bit other than the lowest set bit. It then confirms that every ignored command really is ignored, both while suspended and while the erase runs. A design that wrongly accepted one would drop suspended, add a mask bit, or stretch the total erase time. Finally, it measures the exact suspend latency, checks that suspend does nothing during a chip erase, and checks that a stalled engine trips the limit after exactly LIMIT_CYC cycles and leaves the block idle.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_RUN,
    ST_SUSP_WAIT,
    ST_SUSP
  } sched_st_e;

endpackage

// File: rtl/erase_win_timer.sv
module erase_win_timer #(
  parameter int WIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic expire
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = active && !restart && (cnt_q == CW'(WIN_CYC - 1));
  assign cnt_en = restart || (active && !expire);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (active) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/erase_engine.sv
module erase_engine #(
  parameter int N_SECT    = 8,
  parameter int ERASE_CYC = 8,
  parameter int LIMIT_CYC = 12,
  localparam int SW       = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              stall,
  input  logic [N_SECT-1:0] mask,
  output logic              sect_done,
  output logic [SW-1:0]     sect_idx,
  output logic              limit_hit
);
  localparam int PW = $clog2(ERASE_CYC + 1);
  localparam int LW = $clog2(LIMIT_CYC + 1);

  logic [PW-1:0] prog_q, prog_d;
  logic [LW-1:0] lim_q, lim_d;
  logic          cnt_en;
  logic          any_set;

  // lowest set bit picks the sector under erase
  always_comb begin
    sect_idx = '0;
    for (int i = N_SECT - 1; i >= 0; i--) begin
      if (mask[i]) sect_idx = SW'(i);
    end
  end

  assign any_set   = |mask;
  assign sect_done = run && !stall && any_set && (prog_q == PW'(ERASE_CYC - 1));
  assign limit_hit = run && !sect_done && any_set && (lim_q == LW'(LIMIT_CYC - 1));
  assign cnt_en    = clear || run;

  always_comb begin
    prog_d = prog_q;
    lim_d  = lim_q;
    if (clear || sect_done) begin
      prog_d = '0;
      lim_d  = '0;
    end else if (run) begin
      if (!stall) prog_d = prog_q + PW'(1);
      lim_d = lim_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      lim_q  <= '0;
    end else if (cnt_en) begin
      prog_q <= prog_d;
      lim_q  <= lim_d;
    end
  end
endmodule

// File: rtl/erase_ctrl_fsm.sv
module erase_ctrl_fsm
  import erase_sched_pkg::*;
#(
  parameter int N_SECT   = 8,
  parameter int SUSP_LAT = 4,
  localparam int SW      = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_add,
  input  logic [SW-1:0]     cmd_num,
  input  logic              cmd_chip,
  input  logic              cmd_susp,
  input  logic              cmd_res,
  input  logic              cmd_rst,
  input  logic              cmd_oth,
  input  logic [N_SECT-1:0] prot,
  input  logic              win_expire,
  input  logic              sect_done,
  input  logic [SW-1:0]     sect_idx,
  input  logic              limit_hit,
  output sched_st_e         st,
  output logic [N_SECT-1:0] mask,
  output logic              done,
  output logic              fail,
  output logic              win_restart
);
  localparam int LTW = $clog2(SUSP_LAT + 1);

  sched_st_e         st_d;
  logic [N_SECT-1:0] mask_d, add_bit, fin_bit, left_bits;
  logic              chip_q, chip_d, done_d, fail_d;
  logic [LTW-1:0]    lat_q, lat_d;

  assign add_bit   = (N_SECT'(1) << cmd_num) & ~prot;
  assign fin_bit   = N_SECT'(1) << sect_idx;
  assign left_bits = mask & ~fin_bit;

  always_comb begin
    st_d        = st;
    mask_d      = mask;
    chip_d      = chip_q;
    done_d      = 1'b0;
    fail_d      = fail;
    lat_d       = lat_q;
    win_restart = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (cmd_add) begin
          st_d        = ST_WIN;
          mask_d      = add_bit;
          win_restart = 1'b1;
          fail_d      = 1'b0;
          chip_d      = 1'b0;
        end else if (cmd_chip) begin
          st_d   = ST_RUN;
          mask_d = ~prot;
          chip_d = 1'b1;
          fail_d = 1'b0;
        end
      end
      ST_WIN: begin
        if (cmd_add) begin
          mask_d      = mask | add_bit;
          win_restart = 1'b1;
        end else if (cmd_susp) begin
          st_d = ST_SUSP;
        end else if (cmd_chip || cmd_rst || cmd_oth || cmd_res) begin
          st_d   = ST_IDLE;
          mask_d = '0;
        end else if (win_expire) begin
          st_d = ST_RUN;
        end
      end
      ST_RUN, ST_SUSP_WAIT: begin
        if (mask == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          chip_d = 1'b0;
        end else if (limit_hit) begin
          st_d   = ST_IDLE;
          mask_d = '0;
          fail_d = 1'b1;
          chip_d = 1'b0;
        end else begin
          if (sect_done) mask_d = left_bits;
          if (sect_done && (left_bits == '0)) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            chip_d = 1'b0;
          end else if (st == ST_RUN) begin
            if (cmd_susp && !chip_q) begin
              st_d  = ST_SUSP_WAIT;
              lat_d = '0;
            end
          end else if (lat_q == LTW'(SUSP_LAT - 1)) begin
            st_d = ST_SUSP;
          end else begin
            lat_d = lat_q + LTW'(1);
          end
        end
      end
      ST_SUSP: begin
        if (cmd_res) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mask   <= '0;
      chip_q <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
      lat_q  <= '0;
    end else begin
      st     <= st_d;
      mask   <= mask_d;
      chip_q <= chip_d;
      done   <= done_d;
      fail   <= fail_d;
      lat_q  <= lat_d;
    end
  end
endmodule

// File: rtl/erase_sched.sv
module erase_sched
  import erase_sched_pkg::*;
#(
  parameter int N_SECT    = 8,
  parameter int WIN_CYC   = 20,
  parameter int SUSP_LAT  = 4,
  parameter int ERASE_CYC = 8,
  parameter int LIMIT_CYC = 12,
  localparam int SW       = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_sect_add,
  input  logic [SW-1:0]     cmd_sect_num,
  input  logic              cmd_chip,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic              cmd_reset,
  input  logic              cmd_other,
  input  logic [N_SECT-1:0] protect_mask,
  input  logic              eng_stall,
  output logic              busy,
  output logic              win_open,
  output logic              suspended,
  output logic              done,
  output logic [N_SECT-1:0] sector_mask,
  output logic              timeout_fail
);
  sched_st_e   st;
  logic        rst_meta, rst_sync;
  logic        win_restart, win_expire;
  logic        sect_done, limit_hit;
  logic [SW-1:0] sect_idx;
  logic        eng_clear, eng_run;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign eng_clear = (st == ST_IDLE);
  assign eng_run   = (st == ST_RUN) || (st == ST_SUSP_WAIT);

  erase_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk     (clk),
    .rst_n   (rst_sync),
    .restart (win_restart),
    .active  (st == ST_WIN),
    .expire  (win_expire)
  );

  erase_engine #(
    .N_SECT    (N_SECT),
    .ERASE_CYC (ERASE_CYC),
    .LIMIT_CYC (LIMIT_CYC)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync),
    .clear     (eng_clear),
    .run       (eng_run),
    .stall     (eng_stall),
    .mask      (sector_mask),
    .sect_done (sect_done),
    .sect_idx  (sect_idx),
    .limit_hit (limit_hit)
  );

  erase_ctrl_fsm #(
    .N_SECT   (N_SECT),
    .SUSP_LAT (SUSP_LAT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync),
    .cmd_add     (cmd_sect_add),
    .cmd_num     (cmd_sect_num),
    .cmd_chip    (cmd_chip),
    .cmd_susp    (cmd_suspend),
    .cmd_res     (cmd_resume),
    .cmd_rst     (cmd_reset),
    .cmd_oth     (cmd_other),
    .prot        (protect_mask),
    .win_expire  (win_expire),
    .sect_done   (sect_done),
    .sect_idx    (sect_idx),
    .limit_hit   (limit_hit),
    .st          (st),
    .mask        (sector_mask),
    .done        (done),
    .fail        (timeout_fail),
    .win_restart (win_restart)
  );

  assign busy      = (st != ST_IDLE);
  assign win_open  = (st == ST_WIN);
  assign suspended = (st == ST_SUSP);
endmodule

// File: rtl/erase_sched_chk.sv
module erase_sched_chk #(
  parameter int N_SECT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              win_open,
  input logic              suspended,
  input logic              done,
  input logic [N_SECT-1:0] sector_mask,
  input logic              timeout_fail
);
  AST_WIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (busy && !suspended)); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && sector_mask == '0)); // R3

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($countones($past(sector_mask) & ~sector_mask) <= 1)); // R3

  AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && $past(suspended)) |-> $stable(sector_mask)); // R6

  AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(win_open)) |-> ((sector_mask & ~$past(sector_mask)) == '0)); // R10

  AST_FAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_fail) |-> (!busy && sector_mask == '0)); // R12
endmodule

bind erase_sched erase_sched_chk #(.N_SECT(N_SECT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .win_open     (win_open),
  .suspended    (suspended),
  .done         (done),
  .sector_mask  (sector_mask),
  .timeout_fail (timeout_fail)
);

// File: tb/sim_erase_sched.sv
`timescale 1ns/1ps
module sim_erase_sched;
  localparam int WIN = 20;
  localparam int LAT = 4;
  localparam int ER  = 8;
  localparam int LIM = 12;

  // {protect, sectors requested}
  localparam logic [15:0] VECS [6] = '{
    16'h0001, 16'h0081, 16'h243C, 16'h00FF, 16'hF0A5, 16'hFF12
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       c_add = 1'b0, c_chip = 1'b0, c_susp = 1'b0, c_res = 1'b0;
  logic       c_rst = 1'b0, c_oth = 1'b0, stall = 1'b0;
  logic [2:0] c_num = '0;
  logic [7:0] prot = '0;
  logic       busy, win_open, suspended, done, tfail;
  logic [7:0] smask;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  erase_sched #(
    .N_SECT(8), .WIN_CYC(WIN), .SUSP_LAT(LAT), .ERASE_CYC(ER), .LIMIT_CYC(LIM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_sect_add(c_add), .cmd_sect_num(c_num),
    .cmd_chip(c_chip), .cmd_suspend(c_susp), .cmd_resume(c_res),
    .cmd_reset(c_rst), .cmd_other(c_oth), .protect_mask(prot),
    .eng_stall(stall), .busy(busy), .win_open(win_open),
    .suspended(suspended), .done(done), .sector_mask(smask),
    .timeout_fail(tfail)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // c: {add, chip, suspend, resume, reset, other}
  task automatic send(input logic [5:0] c, input logic [2:0] n);
    {c_add, c_chip, c_susp, c_res, c_rst, c_oth} = c;
    c_num = n;
    @(negedge clk);
    {c_add, c_chip, c_susp, c_res, c_rst, c_oth} = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 600 && !done; i++) @(negedge clk);
  endtask

  task automatic wait_win_closed();
    for (int i = 0; i < 600 && win_open; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] lowest(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return 8'(1) << i;
    return '0;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    int n, c0, k;
    logic [7:0] m, prev, exp_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 win_open", win_open, 0);
    chk("R1 suspended", suspended, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", tfail, 0);
    chk("R1 mask", smask, 0);

    // R3 / R11 table: sectors added highest first, erased lowest first
    for (int v = 0; v < 6; v++) begin
      prot = VECS[v][15:8];
      for (int s = 7; s >= 0; s--) if (VECS[v][s]) send(6'b100000, 3'(s));
      exp_m = VECS[v][7:0] & ~prot;
      k = $countones(exp_m);
      chk("R11 mask after adds", smask, exp_m);
      n = 0;
      prev = smask;
      while (!done && n < 600) begin
        @(negedge clk);
        n++;
        if (smask != prev) begin
          chk("R3 ascending clear", prev & ~smask, lowest(prev));
          prev = smask;
        end
      end
      chk("R3 time to done", n, WIN + ((k == 0) ? 1 : k * ER));
      chk("R3 busy after done", busy, 0);
      @(negedge clk);
      chk("R3 done one cycle", done, 0);
    end
    prot = '0;

    // R2 window length and restart
    send(6'b100000, 3'd1);
    n = 0;
    while (win_open && n < 600) begin n++; @(negedge clk); end
    chk("R2 window length", n, WIN);
    wait_done();
    @(negedge clk);
    send(6'b100000, 3'd1);
    repeat (5) @(negedge clk);
    send(6'b100000, 3'd5);
    chk("R2 mask merged", smask, 8'h22);
    n = 0;
    while (win_open && n < 600) begin n++; @(negedge clk); end
    chk("R2 window restarted", n, WIN);
    wait_done();
    @(negedge clk);

    // R4 abort during window
    send(6'b100000, 3'd3);
    repeat (3) @(negedge clk);
    send(6'b000001, 3'd0);
    chk("R4 other aborts busy", busy, 0);
    chk("R4 other aborts mask", smask, 0);
    send(6'b100000, 3'd3);
    send(6'b010000, 3'd0);
    chk("R4 chip aborts busy", busy, 0);
    chk("R4 chip aborts mask", smask, 0);
    @(negedge clk);

    // R5 suspend in window
    send(6'b100000, 3'd2);
    send(6'b001000, 3'd0);
    chk("R5 suspended at once", suspended, 1);
    chk("R5 window closed", win_open, 0);
    chk("R5 mask kept", smask, 8'h04);
    repeat (30) @(negedge clk);
    chk("R5 still suspended", suspended, 1);
    send(6'b000100, 3'd0);
    n = 0;
    while (!done && n < 600) begin @(negedge clk); n++; end
    chk("R5 erase after resume", n, ER);
    @(negedge clk);

    // R6 R7 R8 suspend during erase
    send(6'b100000, 3'd6);
    send(6'b100000, 3'd0);
    wait_win_closed();
    repeat (2) @(negedge clk);
    send(6'b001000, 3'd0);
    n = 0;
    while (!suspended && n < 600) begin @(negedge clk); n++; end
    chk("R6 suspend latency", n, LAT);
    m = smask;
    send(6'b001000, 3'd0);
    chk("R7 suspend ignored", suspended, 1);
    send(6'b000010, 3'd0);
    chk("R7 reset ignored", suspended, 1);
    send(6'b000001, 3'd0);
    chk("R7 other ignored", suspended, 1);
    send(6'b100000, 3'd7);
    chk("R7 add ignored", smask, m);
    send(6'b010000, 3'd0);
    chk("R7 chip ignored", suspended, 1);
    repeat (20) @(negedge clk);
    chk("R6 mask frozen", smask, m);
    send(6'b000100, 3'd0);
    chk("R7 resume clears", suspended, 0);
    chk("R7 busy after resume", busy, 1);
    send(6'b000100, 3'd0);
    chk("R8 extra resume ignored", {busy, suspended}, 2);
    send(6'b001000, 3'd0);
    n = 0;
    while (!suspended && n < 600) begin @(negedge clk); n++; end
    chk("R8 second suspend latency", n, LAT);
    send(6'b000100, 3'd0);
    wait_done();
    chk("R8 drained mask", smask, 0);
    @(negedge clk);

    // R9 chip erase
    prot = 8'h81;
    send(6'b010000, 3'd0);
    chk("R9 chip mask", smask, 8'h7E);
    chk("R9 no window", win_open, 0);
    send(6'b001000, 3'd0);
    k = 0;
    for (int i = 0; i < LAT + 4; i++) begin
      if (suspended) k = 1;
      @(negedge clk);
    end
    chk("R9 suspend ignored", k, 0);
    wait_done();
    chk("R9 chip completes", smask, 0);
    prot = '0;
    @(negedge clk);

    // R10 commands ignored while running
    send(6'b100000, 3'd6);
    send(6'b100000, 3'd4);
    wait_win_closed();
    c0 = cyc;
    send(6'b000001, 3'd0);
    send(6'b100000, 3'd5);
    chk("R10 no bit added", 32'(smask[5]), 0);
    send(6'b010000, 3'd0);
    send(6'b000010, 3'd0);
    chk("R10 still busy", busy, 1);
    chk("R10 upper bit kept", 32'(smask[6]), 1);
    wait_done();
    chk("R10 total erase time", cyc - c0, 2 * ER);
    @(negedge clk);

    // R12 limit failure
    stall = 1'b1;
    send(6'b100000, 3'd3);
    wait_win_closed();
    c0 = cyc;
    for (int i = 0; i < 600 && !tfail; i++) @(negedge clk);
    chk("R12 limit time", cyc - c0, LIM);
    chk("R12 busy dropped", busy, 0);
    chk("R12 mask cleared", smask, 0);
    stall = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 fail sticky", tfail, 1);
    send(6'b100000, 3'd3);
    chk("R12 fail cleared", tfail, 0);
    wait_done();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule